// File: doc/BRIEF.md
# Dual Four-Bit Addressable Latch

The block holds two banks of four output bits, bank A and bank B. Each bank has its own serial data bit. Both banks share one 2-bit address, an active-low enable and an active-low clear. The enable and clear pins together pick one of four modes:

- **clear** forces every output low.
- **demultiplex** routes each bank's data bit to the addressed output and drives the other outputs low.
- **addressable latch** writes the data bit into the addressed output only, and the other outputs keep their values.
- **memory** freezes every output.

The block is written for a synchronous fabric. Every input is sampled on the rising clock edge and every output is a flip-flop, so no level-sensitive storage is inferred.

A typical use is serial-to-parallel loading. Software steps the address in memory mode, then drops the enable for one cycle to write one bit per bank.

Changing two address bits at once while writing is hazardous on a transparent part. The block flags that case with a one-cycle warning.

Top module: `dual_addr_latch`

## Requirements
- R1: A synchronous active-high `rst` drives all eight outputs and `addr_warn` to 0 at the next rising edge, whatever the mode pins show. It also resets the remembered previous address to 00.
- R2: Clear mode (`en_n`=1, `clr_n`=0) drives all eight outputs to 0 after the next rising edge.
- R3: Demultiplex mode (`en_n`=0, `clr_n`=0) sets the addressed output of each bank to that bank's data bit and every other output to 0 after the next rising edge.
- R4: Addressable-latch mode (`en_n`=0, `clr_n`=1) writes each bank's data bit into its addressed output. The other three outputs of each bank keep their previous values.
- R5: Memory mode (`en_n`=1, `clr_n`=1) keeps all eight outputs unchanged, for any address and data.
- R6: The address value N (0..3, `addr[1]` as MSB) selects output bit N of each bank. Bank A occupies `q[3:0]` and bank B occupies `q[7:4]`, with output N of bank B at `q[4+N]`.
- R7: Bank A takes its data from `din[0]` and bank B from `din[1]`. Both banks obey the shared address and mode in the same cycle.
- R8: `addr_warn` is 1 for the cycle after an edge at which the block was in addressable-latch mode and the sampled address differed in more than one bit from the address sampled at the previous edge. The previous address is updated at every edge, in every mode.
- R9: `addr_warn` stays 0 after a single-bit or no address change, and after any address change made outside addressable-latch mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Shared output select, value N picks output N |
| en_n | input | 1 | Active-low write enable, shared |
| clr_n | input | 1 | Active-low functional clear, shared |
| din | input | 2 | Data bits, bit 0 feeds bank A, bit 1 feeds bank B |
| q | output | 8 | Registered outputs, bank A in [3:0], bank B in [7:4] |
| addr_warn | output | 1 | One-cycle flag for a multi-bit address jump while writing |

## Verification
The bench builds the block with its defaults: two banks of four bits and the warning logic enabled.

This keeps the space small enough to walk every address and every data pair in each of the four modes. An eight-bit reference model is compared with every output after every clock.

The warning is driven through both-bit jumps taken directly in latch mode and jumps staged across a memory-mode cycle. It is also driven through single-bit steps and through jumps made in demultiplex mode, which must stay silent.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    localparam int DEF_BANKS = 2;
    localparam int DEF_BITS  = 4;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_DEMUX = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_HOLD  = 2'd3
    } latch_mode_e;

    function automatic latch_mode_e decode_mode(input logic en_n, input logic clr_n);
        latch_mode_e m;
        case ({en_n, clr_n})
            2'b10:   m = MODE_CLEAR;
            2'b00:   m = MODE_DEMUX;
            2'b01:   m = MODE_WRITE;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alatch_ctrl.sv
module alatch_ctrl
    import addr_latch_pkg::*;
#(
    parameter int BITS   = DEF_BITS,
    parameter int ADDR_W = $clog2(BITS)
) (
    input  logic              en_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    output latch_mode_e       mode,
    output logic [BITS-1:0]   sel
);

    always_comb mode = decode_mode(en_n, clr_n);

    for (genvar i = 0; i < BITS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/alatch_bank.sv
module alatch_bank
    import addr_latch_pkg::*;
#(
    parameter int BITS = DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  latch_mode_e     mode,
    input  logic [BITS-1:0] sel,
    input  logic            din,
    output logic [BITS-1:0] q
);

    logic [BITS-1:0] dmask;
    logic [BITS-1:0] q_next;

    always_comb begin
        dmask = sel & {BITS{din}};
        case (mode)
            MODE_CLEAR: q_next = '0;
            MODE_DEMUX: q_next = dmask;
            MODE_WRITE: q_next = (q & ~sel) | dmask;
            default:    q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));
    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLEAR) |=> (q == '0));
    // R3
    demux_single_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DEMUX) |=> ($countones(q) <= 1));
    // R4
    write_keep_others_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=> (((q ^ $past(q)) & ~$past(sel)) == '0));
    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(q));

endmodule

// File: rtl/alatch_addr_mon.sv
module alatch_addr_mon
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  latch_mode_e       mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              warn
);

    logic [ADDR_W-1:0] prev_addr;
    logic [ADDR_W-1:0] diff;

    assign diff = addr ^ prev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr <= '0;
            warn      <= 1'b0;
        end else begin
            prev_addr <= addr;
            warn      <= (mode == MODE_WRITE) && ($countones(diff) > 1);
        end
    end

    // R8
    warn_only_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        warn |-> ($past(mode) == MODE_WRITE));
    // R9
    warn_quiet_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(addr ^ prev_addr) <= 1) |=> !warn);

endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
    import addr_latch_pkg::*;
#(
    parameter int BANKS    = DEF_BANKS,
    parameter int BITS     = DEF_BITS,
    parameter bit HAS_WARN = 1'b1,
    localparam int ADDR_W  = $clog2(BITS),
    localparam int Q_W     = BANKS * BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_n,
    input  logic              clr_n,
    input  logic [BANKS-1:0]  din,
    output logic [Q_W-1:0]    q,
    output logic              addr_warn
);

    latch_mode_e     mode;
    logic [BITS-1:0] sel;

    alatch_ctrl #(.BITS(BITS), .ADDR_W(ADDR_W)) u_ctrl (
        .en_n  (en_n),
        .clr_n (clr_n),
        .addr  (addr),
        .mode  (mode),
        .sel   (sel)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        alatch_bank #(.BITS(BITS)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .sel  (sel),
            .din  (din[b]),
            .q    (q[b*BITS +: BITS])
        );
    end

    if (HAS_WARN) begin : g_warn
        alatch_addr_mon #(.ADDR_W(ADDR_W)) u_mon (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .addr (addr),
            .warn (addr_warn)
        );
    end else begin : g_nowarn
        assign addr_warn = 1'b0;
    end

    // R7
    banks_share_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(q));

endmodule

// File: tb/dual_addr_latch_tb.sv
`timescale 1ns/1ps
module dual_addr_latch_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = 2'b00;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [1:0] din = 2'b00;
    logic [7:0] q;
    logic       addr_warn;

    int checks = 0;
    int errors = 0;

    logic [7:0] ref_q   = 8'h00;
    logic [1:0] ref_prev = 2'b00;
    logic       ref_warn = 1'b0;

    always #10 clk = ~clk;

    dual_addr_latch u_dut (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .en_n      (en_n),
        .clr_n     (clr_n),
        .din       (din),
        .q         (q),
        .addr_warn (addr_warn)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] a, input logic e, input logic c,
                        input logic [1:0] d, input string tag);
        logic [7:0] nq;
        @(negedge clk);
        addr = a; en_n = e; clr_n = c; din = d;
        nq = ref_q;
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 4; i++) begin
                logic hit;
                hit = (i == int'(a));
                case ({e, c})
                    2'b10: nq[b*4+i] = 1'b0;
                    2'b00: nq[b*4+i] = hit ? d[b] : 1'b0;
                    2'b01: if (hit) nq[b*4+i] = d[b];
                    default: ;
                endcase
            end
        end
        ref_warn = (!e && c) && (a[0] != ref_prev[0]) && (a[1] != ref_prev[1]);
        ref_prev = a;
        ref_q = nq;
        @(negedge clk);
        chk({tag, " q"}, q, ref_q);
        chk({tag, " warn"}, {7'b0, addr_warn}, {7'b0, ref_warn});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; addr = 2'b00; en_n = 1'b0; clr_n = 1'b1; din = 2'b11;
        @(negedge clk);
        @(negedge clk);
        ref_q = 8'h00; ref_prev = 2'b00; ref_warn = 1'b0;
        chk("R1 reset q", q, 8'h00);
        chk("R1 reset warn", {7'b0, addr_warn}, 8'h00);
        rst = 1'b0; en_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        for (int a = 0; a < 4; a++) step(2'(a), 1'b0, 1'b1, 2'b11, "R4 fill");
        do_reset();
        step(2'b00, 1'b1, 1'b1, 2'b00, "R1 after reset hold");
    endtask

    task automatic t_write();
        step(2'b00, 1'b1, 1'b0, 2'b00, "R2 pre-clear");
        for (int a = 0; a < 4; a++)
            for (int d = 0; d < 4; d++)
                step(2'(a), 1'b0, 1'b1, 2'(d), "R4 R6 R7 write");
        step(2'b00, 1'b0, 1'b1, 2'b01, "R7 bank A only");
        step(2'b01, 1'b0, 1'b1, 2'b10, "R7 bank B only");
        step(2'b11, 1'b0, 1'b1, 2'b01, "R6 top bit");
    endtask

    task automatic t_demux();
        for (int a = 0; a < 4; a++) step(2'(a), 1'b0, 1'b1, 2'b11, "R4 fill");
        for (int a = 0; a < 4; a++)
            for (int d = 0; d < 4; d++)
                step(2'(a), 1'b0, 1'b0, 2'(d), "R3 R6 demux");
    endtask

    task automatic t_clear();
        for (int a = 0; a < 4; a++) step(2'(a), 1'b0, 1'b1, 2'b11, "R4 fill");
        for (int d = 0; d < 4; d++) step(2'(d), 1'b1, 1'b0, 2'(d), "R2 clear");
    endtask

    task automatic t_memory();
        step(2'b00, 1'b0, 1'b1, 2'b01, "R4 pattern");
        step(2'b01, 1'b0, 1'b1, 2'b10, "R4 pattern");
        step(2'b10, 1'b0, 1'b1, 2'b11, "R4 pattern");
        for (int a = 0; a < 4; a++)
            for (int d = 0; d < 4; d++)
                step(2'(a), 1'b1, 1'b1, 2'(d), "R5 hold");
    endtask

    task automatic t_warn();
        step(2'b00, 1'b1, 1'b1, 2'b00, "R5 park");
        step(2'b11, 1'b0, 1'b1, 2'b01, "R8 jump 00->11");
        step(2'b10, 1'b0, 1'b1, 2'b01, "R9 single step");
        step(2'b01, 1'b1, 1'b1, 2'b00, "R9 jump in hold");
        step(2'b10, 1'b0, 1'b1, 2'b11, "R8 staged jump");
        step(2'b10, 1'b0, 1'b1, 2'b00, "R9 no change");
        step(2'b01, 1'b0, 1'b0, 2'b11, "R9 jump in demux");
        step(2'b10, 1'b1, 1'b0, 2'b00, "R9 jump in clear");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_demux();
        t_clear();
        t_memory();
        t_warn();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule